// File: doc/BRIEF.md
# Deferred Error Syndrome Register Unit

This unit keeps the 32-bit syndrome word that an error-synchronization barrier writes when it absorbs a pending asynchronous error. It also keeps a second, virtual copy of that word for a guest running below the hypervisor. A barrier event carries the error type, the external-abort flag and a fault code. The unit packs these into one of three bit layouts. The hypervisor level uses one layout. The lower levels use the other two, one for short-descriptor translation and one for long-descriptor translation.

Software reaches the word through coprocessor register accesses. Each access is decoded against a fixed register address. It is then routed through a priority chain:

1. An access from the user level is refused as undefined.
2. A kernel-level access with the hypervisor enabled and its trap control set is trapped with a fixed syndrome code.
3. If external-abort routing goes to the top level, the access is forced to read as zero and write nothing.
4. A kernel-level access with the hypervisor enabled and abort routing set is redirected to the virtual copy.
5. Every other access goes to the real word.

Each selected access gets one registered response on the following cycle.

Top module: `desr_unit`

## Requirements
- R1: After a synchronous reset, both the real and the virtual word read as 0, and `rsp_valid` is low until an access is made.
- R2: A barrier event with a pending error at level 2 or level 3 stores `{A, 19'b0, type[1:0], ext, 3'b0, code[5:0]}`, where A is bit 31.
- R3: A barrier event at level 0 or level 1 with short-descriptor mode stores type in [15:14], ext in [12], code[4] in [10] and code[3:0] in [3:0], with bit 9 = 0 and all other bits 0 apart from A.
- R4: A barrier event at level 0 or level 1 with long-descriptor mode stores type in [15:14], ext in [12], 1 in bit 9 and code[5:0] in [5:0], with all other bits 0 apart from A.
- R5: Bit 31 (A) is 1 on every capture when `HAS_SYNC_SRC` = 1, and it always reads 0 when `HAS_SYNC_SRC` = 0.
- R6: A selected access at level 0 responds with `rsp_undef` = 1 and read data 0, and it leaves both words unchanged.
- R7: A selected level-1 access with `ctx_l2_en` and `ctx_trap_ctl` set responds with `rsp_trap` = 1 and `rsp_code` = 0x03, and it changes nothing. This check takes priority over every later rule.
- R8: A level-1 access that is neither trapped nor zeroed reads or writes the virtual word when `ctx_l2_en` and `ctx_abort_route` are both set, and the real word otherwise.
- R9: Accesses at level 2 and level 3 that are not zeroed always go to the real word.
- R10: An access reads 0 and its write is dropped when all of the following hold:
  - `HAS_TOP_LEVEL` = 1.
  - `ctx_debug` = 0.
  - `ctx_ea_route` = 1.
  - Either the level is 2, or the level is 1 and (`ctx_secure` is set with `ctx_sec_l2_en` clear, or `ctx_abort_route` is clear).
- R11: A read in the same cycle as a capture into the same word returns the captured value. Any later read returns it too.
- R12: Only an access with cp = 15, opc1 = 0, CRn = 12, CRm = 1 and opc2 = 1 is selected. Any other access gets no response and changes nothing.
- R13: A software write keeps only the bits defined by the layout of the current level and mode. The kept bits are 0x80000E3F at level 2 or 3, 0x8000D40F for short-descriptor mode and 0x8000D23F for long-descriptor mode, and bit 31 is dropped when `HAS_SYNC_SRC` = 0. All other bits read 0.
- R14: When a capture and a software write target the same word in one cycle, the captured value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bar_valid | input | 1 | Barrier executed this cycle |
| bar_pending | input | 1 | An asynchronous error is pending at the barrier |
| bar_level | input | 2 | Privilege level of the barrier |
| bar_long_fmt | input | 1 | Long-descriptor mode at the barrier |
| bar_virt | input | 1 | Capture targets the virtual word |
| bar_err_type | input | 2 | Asynchronous error type |
| bar_ext_abort | input | 1 | External-abort type flag |
| bar_code | input | 6 | Fault status code |
| ctx_level | input | 2 | Current privilege level of the access |
| ctx_long_fmt | input | 1 | Current long-descriptor mode |
| ctx_debug | input | 1 | Processor is in debug state |
| ctx_l2_en | input | 1 | Level 2 is enabled |
| ctx_trap_ctl | input | 1 | Level-2 trap control for this register |
| ctx_abort_route | input | 1 | Abort routing to level 2 |
| ctx_ea_route | input | 1 | External-abort routing to the top level |
| ctx_secure | input | 1 | Secure state |
| ctx_sec_l2_en | input | 1 | Secure level 2 enabled |
| acc_valid | input | 1 | Register access request |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_cp | input | 4 | Coprocessor number |
| acc_opc1 | input | 3 | First opcode field |
| acc_crn | input | 4 | Primary register field |
| acc_crm | input | 4 | Secondary register field |
| acc_opc2 | input | 3 | Second opcode field |
| acc_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for a selected access |
| rsp_undef | output | 1 | Undefined-instruction indication |
| rsp_trap | output | 1 | Trap-to-level-2 indication |
| rsp_code | output | 6 | Trap syndrome code |
| rsp_rdata | output | 32 | Read data |

## Verification
The assertions check these rules on every cycle:
- Address selection and the response that follows it.
- The undefined response at level 0.
- The trap priority with its code.
- The zero response under top-level abort routing.
- That undefined and trap are exclusive.
- That reserved bits and, without sync sources, bit 31 never appear in read data.

Only the bench's scenarios can show what the stored words hold: the three capture layouts, virtual redirection, masking on write, capture priority over a write and same-cycle visibility of a capture. Those need a sequence of captures, writes and later reads compared against a model.

// File: rtl/desr_pkg.sv
package desr_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    FMT_HYP   = 2'd0,
    FMT_SHORT = 2'd1,
    FMT_LONG  = 2'd2
  } layout_e;

  typedef enum logic [2:0] {
    RT_IDLE  = 3'd0,
    RT_UNDEF = 3'd1,
    RT_TRAP  = 3'd2,
    RT_ZERO  = 3'd3,
    RT_VIRT  = 3'd4,
    RT_REAL  = 3'd5
  } route_e;

  typedef struct packed {
    logic [1:0] err_type;
    logic       ext_abort;
    logic [5:0] code;
  } err_info_t;

  // Level 2 and above use the hypervisor layout; lower levels follow the mode.
  function automatic layout_e pick_layout(input logic [1:0] lvl, input logic long_fmt);
    if (lvl[1])
      return FMT_HYP;
    return long_fmt ? FMT_LONG : FMT_SHORT;
  endfunction

  // Bits that software may hold in a given layout.
  function automatic logic [WORD_W-1:0] layout_mask(input layout_e f, input logic has_src);
    logic [WORD_W-1:0] m;
    m = '0;
    m[31] = has_src;
    case (f)
      FMT_HYP: begin
        m[11:9] = '1;
        m[5:0]  = '1;
      end
      FMT_SHORT: begin
        m[15:14] = '1;
        m[12]    = 1'b1;
        m[10]    = 1'b1;
        m[3:0]   = '1;
      end
      default: begin
        m[15:14] = '1;
        m[12]    = 1'b1;
        m[9]     = 1'b1;
        m[5:0]   = '1;
      end
    endcase
    return m;
  endfunction

  // Syndrome word stored on a barrier capture.
  function automatic logic [WORD_W-1:0] pack_word(input layout_e f, input logic has_src,
                                                  input err_info_t e);
    logic [WORD_W-1:0] w;
    w = '0;
    w[31] = has_src;
    case (f)
      FMT_HYP: begin
        w[11:10] = e.err_type;
        w[9]     = e.ext_abort;
        w[5:0]   = e.code;
      end
      FMT_SHORT: begin
        w[15:14] = e.err_type;
        w[12]    = e.ext_abort;
        w[10]    = e.code[4];
        w[3:0]   = e.code[3:0];
      end
      default: begin
        w[15:14] = e.err_type;
        w[12]    = e.ext_abort;
        w[9]     = 1'b1;
        w[5:0]   = e.code;
      end
    endcase
    return w;
  endfunction

endpackage

// File: rtl/desr_pack.sv
module desr_pack
  import desr_pkg::*;
#(
  parameter bit HAS_SYNC_SRC = 1'b1
) (
  input  logic [1:0]        bar_level,
  input  logic              bar_long_fmt,
  input  err_info_t         info,
  output logic [WORD_W-1:0] cap_word
);

  layout_e fmt;

  always_comb begin
    fmt      = pick_layout(bar_level, bar_long_fmt);
    cap_word = pack_word(fmt, HAS_SYNC_SRC, info);
  end

endmodule

// File: rtl/desr_route.sv
module desr_route
  import desr_pkg::*;
#(
  parameter bit       HAS_TOP_LEVEL = 1'b1,
  parameter int       CP_NUM        = 15,
  parameter int       OPC1_SEL      = 0,
  parameter int       CRN_SEL       = 12,
  parameter int       CRM_SEL       = 1,
  parameter int       OPC2_SEL      = 1
) (
  input  logic       acc_valid,
  input  logic [3:0] acc_cp,
  input  logic [2:0] acc_opc1,
  input  logic [3:0] acc_crn,
  input  logic [3:0] acc_crm,
  input  logic [2:0] acc_opc2,
  input  logic [1:0] ctx_level,
  input  logic       ctx_debug,
  input  logic       ctx_l2_en,
  input  logic       ctx_trap_ctl,
  input  logic       ctx_abort_route,
  input  logic       ctx_ea_route,
  input  logic       ctx_secure,
  input  logic       ctx_sec_l2_en,
  output route_e     route
);

  logic addr_hit;
  logic lvl0, lvl1, lvl2;
  logic zero_cond;

  assign addr_hit = (acc_cp == 4'(CP_NUM)) && (acc_opc1 == 3'(OPC1_SEL)) &&
                    (acc_crn == 4'(CRN_SEL)) && (acc_crm == 4'(CRM_SEL)) &&
                    (acc_opc2 == 3'(OPC2_SEL));

  assign lvl0 = (ctx_level == 2'd0);
  assign lvl1 = (ctx_level == 2'd1);
  assign lvl2 = (ctx_level == 2'd2);

  assign zero_cond = HAS_TOP_LEVEL && !ctx_debug && ctx_ea_route &&
                     (lvl2 || (lvl1 && ((ctx_secure && !ctx_sec_l2_en) || !ctx_abort_route)));

  always_comb begin
    route = RT_IDLE;
    if (acc_valid && addr_hit) begin
      if (lvl0)
        route = RT_UNDEF;
      else if (lvl1 && ctx_l2_en && ctx_trap_ctl)
        route = RT_TRAP;
      else if (zero_cond)
        route = RT_ZERO;
      else if (lvl1 && ctx_l2_en && ctx_abort_route)
        route = RT_VIRT;
      else
        route = RT_REAL;
    end
  end

endmodule

// File: rtl/desr_regs.sv
module desr_regs
  import desr_pkg::*;
#(
  parameter int NUM_COPIES = 2,
  localparam int IDX_W = (NUM_COPIES > 1) ? $clog2(NUM_COPIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [IDX_W-1:0]  cap_idx,
  input  logic [WORD_W-1:0] cap_word,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  output logic [WORD_W-1:0] fwd [NUM_COPIES]
);

  for (genvar i = 0; i < NUM_COPIES; i++) begin : g_copy
    logic [WORD_W-1:0] q;
    logic cap_hit;
    logic wr_hit;

    assign cap_hit = cap_en && (cap_idx == IDX_W'(i));
    // Capture outranks a software write to the same copy.
    assign wr_hit  = wr_en && (wr_idx == IDX_W'(i)) && !cap_hit;
    // Captured value is visible to a read in the same cycle.
    assign fwd[i]  = cap_hit ? cap_word : q;

    always_ff @(posedge clk) begin
      if (rst)
        q <= '0;
      else if (cap_hit)
        q <= cap_word;
      else if (wr_hit)
        q <= wr_word;
    end
  end

endmodule

// File: rtl/desr_unit.sv
module desr_unit
  import desr_pkg::*;
#(
  parameter bit HAS_SYNC_SRC  = 1'b1,
  parameter bit HAS_TOP_LEVEL = 1'b1,
  parameter int CP_NUM        = 15,
  parameter int OPC1_SEL      = 0,
  parameter int CRN_SEL       = 12,
  parameter int CRM_SEL       = 1,
  parameter int OPC2_SEL      = 1,
  parameter int TRAP_CODE     = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bar_valid,
  input  logic        bar_pending,
  input  logic [1:0]  bar_level,
  input  logic        bar_long_fmt,
  input  logic        bar_virt,
  input  logic [1:0]  bar_err_type,
  input  logic        bar_ext_abort,
  input  logic [5:0]  bar_code,
  input  logic [1:0]  ctx_level,
  input  logic        ctx_long_fmt,
  input  logic        ctx_debug,
  input  logic        ctx_l2_en,
  input  logic        ctx_trap_ctl,
  input  logic        ctx_abort_route,
  input  logic        ctx_ea_route,
  input  logic        ctx_secure,
  input  logic        ctx_sec_l2_en,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [3:0]  acc_cp,
  input  logic [2:0]  acc_opc1,
  input  logic [3:0]  acc_crn,
  input  logic [3:0]  acc_crm,
  input  logic [2:0]  acc_opc2,
  input  logic [31:0] acc_wdata,
  output logic        rsp_valid,
  output logic        rsp_undef,
  output logic        rsp_trap,
  output logic [5:0]  rsp_code,
  output logic [31:0] rsp_rdata
);

  localparam int NUM_COPIES = 2;
  localparam int IDX_REAL   = 0;
  localparam int IDX_VIRT   = 1;

  err_info_t         info;
  logic [WORD_W-1:0] cap_word;
  route_e            route;
  logic              cap_en;
  logic              wr_en;
  logic              wr_idx;
  logic [WORD_W-1:0] wr_word;
  logic [WORD_W-1:0] fwd [NUM_COPIES];
  logic [WORD_W-1:0] rd_word;

  assign info = '{err_type: bar_err_type, ext_abort: bar_ext_abort, code: bar_code};

  desr_pack #(.HAS_SYNC_SRC(HAS_SYNC_SRC)) pack_i (
    .bar_level    (bar_level),
    .bar_long_fmt (bar_long_fmt),
    .info         (info),
    .cap_word     (cap_word)
  );

  desr_route #(
    .HAS_TOP_LEVEL (HAS_TOP_LEVEL),
    .CP_NUM        (CP_NUM),
    .OPC1_SEL      (OPC1_SEL),
    .CRN_SEL       (CRN_SEL),
    .CRM_SEL       (CRM_SEL),
    .OPC2_SEL      (OPC2_SEL)
  ) route_i (
    .acc_valid       (acc_valid),
    .acc_cp          (acc_cp),
    .acc_opc1        (acc_opc1),
    .acc_crn         (acc_crn),
    .acc_crm         (acc_crm),
    .acc_opc2        (acc_opc2),
    .ctx_level       (ctx_level),
    .ctx_debug       (ctx_debug),
    .ctx_l2_en       (ctx_l2_en),
    .ctx_trap_ctl    (ctx_trap_ctl),
    .ctx_abort_route (ctx_abort_route),
    .ctx_ea_route    (ctx_ea_route),
    .ctx_secure      (ctx_secure),
    .ctx_sec_l2_en   (ctx_sec_l2_en),
    .route           (route)
  );

  assign cap_en  = bar_valid && bar_pending;
  assign wr_en   = acc_write && ((route == RT_REAL) || (route == RT_VIRT));
  assign wr_idx  = (route == RT_VIRT);
  assign wr_word = acc_wdata & layout_mask(pick_layout(ctx_level, ctx_long_fmt), HAS_SYNC_SRC);

  desr_regs #(.NUM_COPIES(NUM_COPIES)) regs_i (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (cap_en),
    .cap_idx  (bar_virt),
    .cap_word (cap_word),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_word  (wr_word),
    .fwd      (fwd)
  );

  always_comb begin
    rd_word = '0;
    if (!acc_write) begin
      if (route == RT_REAL)
        rd_word = fwd[IDX_REAL];
      else if (route == RT_VIRT)
        rd_word = fwd[IDX_VIRT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_undef <= 1'b0;
      rsp_trap  <= 1'b0;
      rsp_code  <= '0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= (route != RT_IDLE);
      rsp_undef <= (route == RT_UNDEF);
      rsp_trap  <= (route == RT_TRAP);
      rsp_code  <= (route == RT_TRAP) ? 6'(TRAP_CODE) : 6'd0;
      rsp_rdata <= rd_word;
    end
  end

endmodule

// File: rtl/desr_unit_chk.sv
module desr_unit_chk #(
  parameter bit HAS_SYNC_SRC  = 1'b1,
  parameter bit HAS_TOP_LEVEL = 1'b1,
  parameter int CP_NUM        = 15,
  parameter int OPC1_SEL      = 0,
  parameter int CRN_SEL       = 12,
  parameter int CRM_SEL       = 1,
  parameter int OPC2_SEL      = 1,
  parameter int TRAP_CODE     = 3
) (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  ctx_level,
  input logic        ctx_debug,
  input logic        ctx_l2_en,
  input logic        ctx_trap_ctl,
  input logic        ctx_abort_route,
  input logic        ctx_ea_route,
  input logic        ctx_secure,
  input logic        ctx_sec_l2_en,
  input logic        acc_valid,
  input logic [3:0]  acc_cp,
  input logic [2:0]  acc_opc1,
  input logic [3:0]  acc_crn,
  input logic [3:0]  acc_crm,
  input logic [2:0]  acc_opc2,
  input logic        rsp_valid,
  input logic        rsp_undef,
  input logic        rsp_trap,
  input logic [5:0]  rsp_code,
  input logic [31:0] rsp_rdata
);

  logic sel;
  logic trap_c;
  logic zero_c;

  assign sel = acc_valid && (acc_cp == 4'(CP_NUM)) && (acc_opc1 == 3'(OPC1_SEL)) &&
               (acc_crn == 4'(CRN_SEL)) && (acc_crm == 4'(CRM_SEL)) &&
               (acc_opc2 == 3'(OPC2_SEL));
  assign trap_c = sel && (ctx_level == 2'd1) && ctx_l2_en && ctx_trap_ctl;
  assign zero_c = sel && HAS_TOP_LEVEL && !ctx_debug && ctx_ea_route && !trap_c &&
                  ((ctx_level == 2'd2) ||
                   ((ctx_level == 2'd1) && ((ctx_secure && !ctx_sec_l2_en) || !ctx_abort_route)));

  a_r12_select_response: assert property (@(posedge clk) disable iff (rst)
    sel |=> rsp_valid);

  a_r12_no_select_quiet: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !rsp_valid);

  a_r6_user_undef: assert property (@(posedge clk) disable iff (rst)
    (sel && ctx_level == 2'd0) |=> (rsp_undef && !rsp_trap && rsp_rdata == 32'd0));

  a_r7_trap_code: assert property (@(posedge clk) disable iff (rst)
    trap_c |=> (rsp_trap && !rsp_undef && rsp_code == 6'(TRAP_CODE) && rsp_rdata == 32'd0));

  a_r10_zero_read: assert property (@(posedge clk) disable iff (rst)
    zero_c |=> (rsp_rdata == 32'd0 && !rsp_trap && !rsp_undef));

  a_r7_exclusive_flags: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_undef, rsp_trap}));

  a_r13_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_rdata & 32'h7FFF_21C0) == 32'd0);

  a_r5_no_source_bit: assert property (@(posedge clk) disable iff (rst)
    !HAS_SYNC_SRC |-> !rsp_rdata[31]);

endmodule

bind desr_unit desr_unit_chk #(
  .HAS_SYNC_SRC  (HAS_SYNC_SRC),
  .HAS_TOP_LEVEL (HAS_TOP_LEVEL),
  .CP_NUM        (CP_NUM),
  .OPC1_SEL      (OPC1_SEL),
  .CRN_SEL       (CRN_SEL),
  .CRM_SEL       (CRM_SEL),
  .OPC2_SEL      (OPC2_SEL),
  .TRAP_CODE     (TRAP_CODE)
) chk_i (
  .clk             (clk),
  .rst             (rst),
  .ctx_level       (ctx_level),
  .ctx_debug       (ctx_debug),
  .ctx_l2_en       (ctx_l2_en),
  .ctx_trap_ctl    (ctx_trap_ctl),
  .ctx_abort_route (ctx_abort_route),
  .ctx_ea_route    (ctx_ea_route),
  .ctx_secure      (ctx_secure),
  .ctx_sec_l2_en   (ctx_sec_l2_en),
  .acc_valid       (acc_valid),
  .acc_cp          (acc_cp),
  .acc_opc1        (acc_opc1),
  .acc_crn         (acc_crn),
  .acc_crm         (acc_crm),
  .acc_opc2        (acc_opc2),
  .rsp_valid       (rsp_valid),
  .rsp_undef       (rsp_undef),
  .rsp_trap        (rsp_trap),
  .rsp_code        (rsp_code),
  .rsp_rdata       (rsp_rdata)
);

// File: tb/desr_unit_tb_top.sv
`timescale 1ns/1ps
module desr_unit_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        bar_valid, bar_pending, bar_long_fmt, bar_virt, bar_ext_abort;
  logic [1:0]  bar_level, bar_err_type;
  logic [5:0]  bar_code;
  logic [1:0]  ctx_level;
  logic        ctx_long_fmt, ctx_debug, ctx_l2_en, ctx_trap_ctl;
  logic        ctx_abort_route, ctx_ea_route, ctx_secure, ctx_sec_l2_en;
  logic        acc_valid, acc_write;
  logic [3:0]  acc_cp, acc_crn, acc_crm;
  logic [2:0]  acc_opc1, acc_opc2;
  logic [31:0] acc_wdata;

  logic        o_valid [2];
  logic        o_undef [2];
  logic        o_trap  [2];
  logic [5:0]  o_code  [2];
  logic [31:0] o_rdata [2];

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;
  logic [31:0] m_reg [2][2];  // [dut][copy]: copy 0 real, 1 virtual

  desr_unit #(.HAS_SYNC_SRC(1'b1)) dut_i (
    .clk(clk), .rst(rst), .bar_valid(bar_valid), .bar_pending(bar_pending),
    .bar_level(bar_level), .bar_long_fmt(bar_long_fmt), .bar_virt(bar_virt),
    .bar_err_type(bar_err_type), .bar_ext_abort(bar_ext_abort), .bar_code(bar_code),
    .ctx_level(ctx_level), .ctx_long_fmt(ctx_long_fmt), .ctx_debug(ctx_debug),
    .ctx_l2_en(ctx_l2_en), .ctx_trap_ctl(ctx_trap_ctl), .ctx_abort_route(ctx_abort_route),
    .ctx_ea_route(ctx_ea_route), .ctx_secure(ctx_secure), .ctx_sec_l2_en(ctx_sec_l2_en),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_cp(acc_cp), .acc_opc1(acc_opc1),
    .acc_crn(acc_crn), .acc_crm(acc_crm), .acc_opc2(acc_opc2), .acc_wdata(acc_wdata),
    .rsp_valid(o_valid[0]), .rsp_undef(o_undef[0]), .rsp_trap(o_trap[0]),
    .rsp_code(o_code[0]), .rsp_rdata(o_rdata[0]));

  desr_unit #(.HAS_SYNC_SRC(1'b0)) dut_ns_i (
    .clk(clk), .rst(rst), .bar_valid(bar_valid), .bar_pending(bar_pending),
    .bar_level(bar_level), .bar_long_fmt(bar_long_fmt), .bar_virt(bar_virt),
    .bar_err_type(bar_err_type), .bar_ext_abort(bar_ext_abort), .bar_code(bar_code),
    .ctx_level(ctx_level), .ctx_long_fmt(ctx_long_fmt), .ctx_debug(ctx_debug),
    .ctx_l2_en(ctx_l2_en), .ctx_trap_ctl(ctx_trap_ctl), .ctx_abort_route(ctx_abort_route),
    .ctx_ea_route(ctx_ea_route), .ctx_secure(ctx_secure), .ctx_sec_l2_en(ctx_sec_l2_en),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_cp(acc_cp), .acc_opc1(acc_opc1),
    .acc_crn(acc_crn), .acc_crm(acc_crm), .acc_opc2(acc_opc2), .acc_wdata(acc_wdata),
    .rsp_valid(o_valid[1]), .rsp_undef(o_undef[1]), .rsp_trap(o_trap[1]),
    .rsp_code(o_code[1]), .rsp_rdata(o_rdata[1]));

  // Write masks per R13: 0x..0E3F hyp, 0x..D40F short, 0x..D23F long, bit 31 if sources.
  function automatic logic [31:0] exp_mask(input logic [1:0] lvl, input logic lng, input bit has);
    logic [31:0] m;
    if (lvl >= 2) m = 32'h0000_0E3F;
    else if (lng) m = 32'h0000_D23F;
    else m = 32'h0000_D40F;
    m[31] = has;
    return m;
  endfunction

  // Capture layouts per R2, R3, R4.
  function automatic logic [31:0] exp_pack(input logic [1:0] lvl, input logic lng, input bit has,
                                           input logic [1:0] et, input logic ext,
                                           input logic [5:0] code);
    if (lvl >= 2) return {has, 19'b0, et, ext, 3'b0, code};
    if (lng) return {has, 15'b0, et, 1'b0, ext, 2'b0, 1'b1, 3'b0, code};
    return {has, 15'b0, et, 1'b0, ext, 1'b0, code[4], 1'b0, 5'b0, code[3:0]};
  endfunction

  // 0 none, 1 undef, 2 trap, 3 zero, 4 virtual, 5 real (R6..R10, R12).
  function automatic int exp_route();
    bit hit;
    bit z;
    hit = (acc_cp == 4'd15) && (acc_opc1 == 3'd0) && (acc_crn == 4'd12) &&
          (acc_crm == 4'd1) && (acc_opc2 == 3'd1);
    if (!acc_valid || !hit) return 0;
    if (ctx_level == 2'd0) return 1;
    if (ctx_level == 2'd1 && ctx_l2_en && ctx_trap_ctl) return 2;
    z = !ctx_debug && ctx_ea_route &&
        (ctx_level == 2'd2 ||
         (ctx_level == 2'd1 && ((ctx_secure && !ctx_sec_l2_en) || !ctx_abort_route)));
    if (z) return 3;
    if (ctx_level == 2'd1 && ctx_l2_en && ctx_abort_route) return 4;
    return 5;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    bar_valid = 0; bar_pending = 0; bar_level = 0; bar_long_fmt = 0; bar_virt = 0;
    bar_err_type = 0; bar_ext_abort = 0; bar_code = 0;
    acc_valid = 0; acc_write = 0; acc_wdata = 0;
    acc_cp = 4'd15; acc_opc1 = 0; acc_crn = 4'd12; acc_crm = 4'd1; acc_opc2 = 3'd1;
  endtask

  task automatic set_ctx(input logic [1:0] lvl, input logic lng, input logic l2,
                         input logic trp, input logic ar, input logic ea);
    ctx_level = lvl; ctx_long_fmt = lng; ctx_l2_en = l2; ctx_trap_ctl = trp;
    ctx_abort_route = ar; ctx_ea_route = ea; ctx_debug = 0; ctx_secure = 0; ctx_sec_l2_en = 0;
  endtask

  task automatic set_acc(input logic wr, input logic [31:0] wd);
    acc_valid = 1; acc_write = wr; acc_wdata = wd;
  endtask

  task automatic set_bar(input logic [1:0] lvl, input logic lng, input logic virt,
                         input logic [1:0] et, input logic ext, input logic [5:0] code);
    bar_valid = 1; bar_pending = 1; bar_level = lvl; bar_long_fmt = lng; bar_virt = virt;
    bar_err_type = et; bar_ext_abort = ext; bar_code = code;
  endtask

  // One clock: model the cycle, then compare both units at the next falling edge.
  task automatic cycle(input string tag);
    int rt;
    bit capt;
    int c;
    string t;
    logic [31:0] nxt [2][2];
    logic [31:0] exp_rd [2];
    rt = exp_route();
    capt = bar_valid && bar_pending;
    for (int d = 0; d < 2; d++) begin
      for (int k = 0; k < 2; k++) nxt[d][k] = m_reg[d][k];
      if (capt)
        nxt[d][bar_virt] = exp_pack(bar_level, bar_long_fmt, d == 0,
                                    bar_err_type, bar_ext_abort, bar_code);
      exp_rd[d] = 32'd0;
      if (!acc_write && rt == 5) exp_rd[d] = nxt[d][0];
      if (!acc_write && rt == 4) exp_rd[d] = nxt[d][1];
      if (acc_write && (rt == 4 || rt == 5)) begin
        c = (rt == 4) ? 1 : 0;
        if (!(capt && bar_virt == c[0]))
          nxt[d][c] = acc_wdata & exp_mask(ctx_level, ctx_long_fmt, d == 0);
      end
    end
    if (tag != "") t = tag;
    else case (rt)
      0: t = "R12";
      1: t = "R6";
      2: t = "R7";
      3: t = "R10";
      4: t = "R8";
      default: t = (ctx_level >= 2) ? "R9" : "R8";
    endcase
    @(posedge clk);
    @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      check(o_valid[d] === (rt != 0) && o_undef[d] === (rt == 1) && o_trap[d] === (rt == 2) &&
            o_code[d] === ((rt == 2) ? 6'd3 : 6'd0) && o_rdata[d] === exp_rd[d],
            t, (d == 0) ? "resp" : "resp(no-src)",
            {o_valid[d], o_undef[d], o_trap[d], 23'd0, o_code[d], o_rdata[d]},
            {rt != 0, rt == 1, rt == 2, 23'd0, (rt == 2) ? 6'd3 : 6'd0, exp_rd[d]});
      for (int k = 0; k < 2; k++) m_reg[d][k] = nxt[d][k];
    end
    idle();
  endtask

  task automatic read_real(input string tag);
    set_ctx(2'd3, 0, 0, 0, 0, 0); set_acc(0, 0); cycle(tag);
  endtask

  task automatic read_virt(input string tag);
    set_ctx(2'd1, 0, 1, 0, 1, 0); set_acc(0, 0); cycle(tag);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int d = 0; d < 2; d++) for (int k = 0; k < 2; k++) m_reg[d][k] = 32'd0;
    idle();
    set_ctx(0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset state
    cycle("R1");
    read_real("R1");
    read_virt("R1");

    // R2 / R5: hypervisor layout capture
    set_bar(2'd2, 0, 0, 2'b10, 1, 6'h11); cycle("R2");
    read_real("R2");
    check(o_rdata[0][31] === 1'b1 && o_rdata[1][31] === 1'b0, "R5", "bit31 both units",
          {o_rdata[0][31], o_rdata[1][31]}, 64'h2);
    // R3: short-descriptor layout
    set_bar(2'd1, 0, 0, 2'b01, 1, 6'h16); cycle("R3");
    read_real("R3");
    // R4: long-descriptor layout
    set_bar(2'd0, 1, 0, 2'b11, 0, 6'h25); cycle("R4");
    read_real("R4");
    // R11: capture and read in the same cycle
    set_bar(2'd3, 0, 0, 2'b01, 0, 6'h3A); read_real("R11");
    read_real("R11");
    // R14: capture beats a write to the same word
    set_bar(2'd2, 0, 0, 2'b00, 1, 6'h07); set_ctx(2'd3, 0, 0, 0, 0, 0);
    set_acc(1, 32'hFFFF_FFFF); cycle("R14");
    read_real("R14");
    // R13: write masking per layout
    set_ctx(2'd2, 0, 0, 0, 0, 0); set_acc(1, 32'hFFFF_FFFF); cycle("R13");
    read_real("R13");
    set_ctx(2'd1, 0, 0, 0, 0, 0); set_acc(1, 32'hFFFF_FFFF); cycle("R13");
    read_real("R13");
    set_ctx(2'd1, 1, 0, 0, 0, 0); set_acc(1, 32'hFFFF_FFFF); cycle("R13");
    read_real("R13");
    // R12: non-matching address leaves state untouched
    set_ctx(2'd3, 0, 0, 0, 0, 0); set_acc(1, 32'h0); acc_crm = 4'd2; cycle("R12");
    read_real("R12");
    // R6: user-level access refused
    set_ctx(2'd0, 0, 0, 0, 0, 0); set_acc(1, 32'h0); cycle("R6");
    read_real("R6");
    // R7: trap outranks zeroing and redirect
    set_ctx(2'd1, 0, 1, 1, 1, 1); set_acc(1, 32'h0); cycle("R7");
    read_real("R7");
    read_virt("R7");
    // R10: zeroed access at level 2, write dropped
    set_ctx(2'd2, 0, 0, 0, 0, 1); set_acc(1, 32'h0); cycle("R10");
    set_ctx(2'd2, 0, 0, 0, 0, 1); set_acc(0, 0); cycle("R10");
    read_real("R10");
    // R10: secure level 1 with secure level 2 off zeroes despite redirect
    set_ctx(2'd1, 0, 1, 0, 1, 1); ctx_secure = 1; set_acc(0, 0); cycle("R10");
    // R8: redirect to virtual word, real word unaffected
    set_ctx(2'd1, 1, 1, 0, 1, 0); set_acc(1, 32'h8000_C23F); cycle("R8");
    read_virt("R8");
    read_real("R8");
    set_bar(2'd1, 0, 1, 2'b10, 1, 6'h1F); cycle("R8");
    read_virt("R8");
    // R9: level 3 ignores top-level routing
    set_ctx(2'd3, 0, 1, 1, 1, 1); set_acc(0, 0); cycle("R9");

    // Random mix
    for (int i = 0; i < 1500; i++) begin
      ctx_level = 2'($urandom); ctx_long_fmt = 1'($urandom); ctx_debug = ($urandom % 4) == 0;
      ctx_l2_en = 1'($urandom); ctx_trap_ctl = ($urandom % 4) == 0;
      ctx_abort_route = 1'($urandom); ctx_ea_route = 1'($urandom);
      ctx_secure = 1'($urandom); ctx_sec_l2_en = 1'($urandom);
      acc_valid = ($urandom % 4) != 0; acc_write = 1'($urandom); acc_wdata = $urandom;
      if (($urandom % 8) == 0) begin
        acc_cp = 4'($urandom); acc_opc1 = 3'($urandom); acc_crn = 4'($urandom);
        acc_crm = 4'($urandom); acc_opc2 = 3'($urandom);
      end
      if (($urandom % 3) == 0)
        set_bar(2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
                6'($urandom));
      bar_pending = ($urandom % 5) != 0;
      cycle("");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule